// File: doc/BRIEF.md
# Bit-Error-Rate Loss-of-Signal Detector

This block sits behind a bang-bang (three-sample) phase detector in the recovered-clock domain. For every recovered bit it receives the centre sample of the current bit, the sample taken near the expected transition, and the centre sample of the following bit. If the two centre samples agree, no transition took place. If the transition sample still disagrees with them in that case, the sample was corrupted. The block counts these corrupted-sample events and treats their density as an estimate of the bit error rate. It needs no knowledge of framing or payload, so any bitstream can be monitored.

A short sliding window raises the loss-of-signal alarm quickly when errors are dense. The alarm can only be removed after a long block of bits shows a low error count, which gives a wide hysteresis band. A long run of bits without any data transition is read as a missing signal and also raises the alarm. The alarm is active high by default, and a parameter inverts it. A saturating total of error events is also output for debug.

Top module: `ber_los_detector`

## Requirements
- R1: A sample error is a valid bit whose two centre samples are equal while the transition sample differs from them. Each such bit adds one to `err_count`, which saturates at its all-ones value. Every other bit leaves `err_count` unchanged.
- R2: When the errors among the last `ASSERT_WIN` valid bits (the current bit included) reach `ASSERT_THR`, the alarm is set at the clock edge that takes in that bit. A window holding fewer errors does not set it.
- R3: While the alarm is set, the valid bits are grouped into clean blocks of `CLEAR_WIN` bits. A block that ends with more than `CLEAR_MAX` errors leaves the alarm set, and a new block starts.
- R4: A clean block that ends with at most `CLEAR_MAX` errors clears the alarm at the edge that takes in its last bit. The alarm clears at no other time.
- R5: A transition is a valid bit whose two centre samples differ. When the current run of valid bits without a transition exceeds `QUIET_LIMIT`, the alarm is set. A run of exactly `QUIET_LIMIT` bits does not set it.
- R6: While the alarm is set, any bit that meets the condition of R2 or R5 discards the block in progress, and the next clean block starts with the following bit. The result does not depend on the data values, only on the error and transition events.
- R7: `los` is high for alarm when `INVERT` is 0, and it is the complement of the alarm when `INVERT` is 1.
- R8: Synchronous reset sets the alarm, clears `err_count`, the window history, the no-transition run and the clean block.
- R9: A cycle with `samp_valid` low changes neither the alarm nor `err_count`, whatever the sample inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_valid | input | 1 | The three samples below belong to one recovered bit |
| samp_early | input | 1 | Centre sample of the current bit |
| samp_mid | input | 1 | Sample at the expected transition |
| samp_late | input | 1 | Centre sample of the following bit |
| los | output | 1 | Loss-of-signal alarm, polarity set by `INVERT` |
| err_count | output | CNT_W | Saturating total of sample-error events |

## Verification
The bench builds the detector with an 8-bit assert window, a threshold of 3, clean blocks of 32 bits that tolerate 2 errors, a no-transition limit of 16 and an 8-bit error counter. A second copy uses the inverted polarity. At these sizes the bench can reach every boundary with short sequences: the edge at which a block expires, the change from 2 to 3 errors in a window, a run of 16 against 17 bits without a transition, and counter saturation. A bench model built from the requirements is compared with the outputs on every cycle. Runs include all eight sample combinations, idle cycles and a long pseudo-random stream.

// File: rtl/ber_los_pkg.sv
package ber_los_pkg;

    typedef struct packed {
        logic early;
        logic mid;
        logic late;
    } pd_samples_t;

    // centre samples agree, transition sample disagrees
    function automatic logic is_sample_error(pd_samples_t s);
        return (s.early == s.late) && (s.mid != s.early);
    endfunction

    function automatic logic is_transition(pd_samples_t s);
        return s.early != s.late;
    endfunction

endpackage

// File: rtl/err_classify.sv
module err_classify
    import ber_los_pkg::*;
(
    input  pd_samples_t smp,
    output logic        err_o,
    output logic        trans_o
);
    always_comb begin
        err_o   = is_sample_error(smp);
        trans_o = is_transition(smp);
    end
endmodule

// File: rtl/slide_window.sv
module slide_window #(
    parameter int WIN = 64,
    localparam int CW = $clog2(WIN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          err_in,
    output logic [CW-1:0] cnt_q_o,
    output logic [CW-1:0] cnt_d_o
);
    typedef struct packed {
        logic [WIN-1:0] hist;
        logic [CW-1:0]  cnt;
    } win_state_t;

    win_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (step) begin
            s_d.hist = {s_q.hist[WIN-2:0], err_in};
            s_d.cnt  = s_q.cnt + CW'(err_in) - CW'(s_q.hist[WIN-1]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign cnt_q_o = s_q.cnt;
    assign cnt_d_o = s_d.cnt;
endmodule

// File: rtl/quiet_timer.sv
module quiet_timer #(
    parameter int LIMIT = 2048,
    localparam int RW = $clog2(LIMIT + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          trans,
    output logic          quiet_d_o,
    output logic [RW-1:0] run_q_o
);
    localparam logic [RW-1:0] LIM_V = RW'(LIMIT);
    localparam logic [RW-1:0] TOP_V = RW'(LIMIT + 1);

    logic [RW-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (step) begin
            if (trans)               run_d = '0;
            else if (run_q != TOP_V) run_d = run_q + 1'b1;
        end
        quiet_d_o = run_d > LIM_V;
    end

    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else     run_q <= run_d;
    end

    assign run_q_o = run_q;
endmodule

// File: rtl/ber_los_detector.sv
module ber_los_detector
    import ber_los_pkg::*;
#(
    parameter int ASSERT_WIN  = 64,
    parameter int ASSERT_THR  = 3,
    parameter int CLEAR_WIN   = 4096,
    parameter int CLEAR_MAX   = 4,
    parameter int QUIET_LIMIT = 2048,
    parameter int CNT_W       = 16,
    parameter bit INVERT      = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             samp_valid,
    input  logic             samp_early,
    input  logic             samp_mid,
    input  logic             samp_late,
    output logic             los,
    output logic [CNT_W-1:0] err_count
);
    localparam int WCW = $clog2(ASSERT_WIN + 1);
    localparam int RW  = $clog2(QUIET_LIMIT + 2);
    localparam int BW  = $clog2(CLEAR_WIN + 1);
    localparam int EW  = $clog2(CLEAR_MAX + 2);
    localparam logic [WCW-1:0] THR_V  = WCW'(ASSERT_THR);
    localparam logic [BW-1:0]  BLK_V  = BW'(CLEAR_WIN);
    localparam logic [EW-1:0]  EMAX_V = EW'(CLEAR_MAX);
    localparam logic [EW-1:0]  ESAT_V = EW'(CLEAR_MAX + 1);

    typedef struct packed {
        logic             alarm;
        logic [BW-1:0]    blk_bits;
        logic [EW-1:0]    blk_errs;
        logic [CNT_W-1:0] total;
    } det_state_t;

    det_state_t    s_d, s_q;
    pd_samples_t   smp;
    logic          bit_err, bit_trans, quiet_d, trigger;
    logic [WCW-1:0] win_cnt_q, win_cnt_d;
    logic [RW-1:0]  run_q;
    logic [BW-1:0]  bits_inc;
    logic [EW-1:0]  errs_inc;
    logic           alarm_q;

    assign smp = '{early: samp_early, mid: samp_mid, late: samp_late};

    err_classify u_cls (
        .smp     (smp),
        .err_o   (bit_err),
        .trans_o (bit_trans)
    );

    slide_window #(.WIN(ASSERT_WIN)) u_win (
        .clk     (clk),
        .rst     (rst),
        .step    (samp_valid),
        .err_in  (bit_err),
        .cnt_q_o (win_cnt_q),
        .cnt_d_o (win_cnt_d)
    );

    quiet_timer #(.LIMIT(QUIET_LIMIT)) u_quiet (
        .clk       (clk),
        .rst       (rst),
        .step      (samp_valid),
        .trans     (bit_trans),
        .quiet_d_o (quiet_d),
        .run_q_o   (run_q)
    );

    always_comb begin
        s_d      = s_q;
        trigger  = (win_cnt_d >= THR_V) || quiet_d;
        bits_inc = s_q.blk_bits + 1'b1;
        errs_inc = s_q.blk_errs;
        if (bit_err && (s_q.blk_errs != ESAT_V)) errs_inc = s_q.blk_errs + 1'b1;

        if (samp_valid) begin
            if (bit_err && (s_q.total != '1)) s_d.total = s_q.total + 1'b1;

            if (trigger) begin
                s_d.alarm    = 1'b1;
                s_d.blk_bits = '0;
                s_d.blk_errs = '0;
            end else if (s_q.alarm) begin
                if (bits_inc == BLK_V) begin
                    if (errs_inc <= EMAX_V) s_d.alarm = 1'b0;
                    s_d.blk_bits = '0;
                    s_d.blk_errs = '0;
                end else begin
                    s_d.blk_bits = bits_inc;
                    s_d.blk_errs = errs_inc;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q       <= '0;
            s_q.alarm <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign alarm_q   = s_q.alarm;
    assign err_count = s_q.total;

    generate
        if (INVERT) begin : g_inv
            assign los = ~s_q.alarm;
        end else begin : g_pos
            assign los = s_q.alarm;
        end
    endgenerate
endmodule

module ber_los_checker #(
    parameter int ASSERT_THR  = 3,
    parameter int QUIET_LIMIT = 2048,
    parameter int CNT_W       = 16,
    parameter int WCW         = 7,
    parameter int RW          = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             samp_valid,
    input logic             samp_early,
    input logic             samp_mid,
    input logic             samp_late,
    input logic             alarm_q,
    input logic [CNT_W-1:0] err_count,
    input logic [WCW-1:0]   win_cnt_q,
    input logic [RW-1:0]    run_q
);
    // R1
    err_step_chk: assert property (@(posedge clk) disable iff (rst)
        (samp_valid && (samp_early == samp_late) && (samp_mid != samp_early) && (err_count != '1))
        |=> (err_count == $past(err_count) + 1'b1));

    // R1
    count_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (err_count >= $past(err_count)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !samp_valid |=> ($stable(alarm_q) && $stable(err_count)));

    // R2
    burst_alarm_chk: assert property (@(posedge clk) disable iff (rst)
        (win_cnt_q >= WCW'(ASSERT_THR)) |-> alarm_q);

    // R5
    quiet_alarm_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q > RW'(QUIET_LIMIT)) |-> alarm_q);

    // R4
    clear_on_bit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(alarm_q) |-> $past(samp_valid));
endmodule

bind ber_los_detector ber_los_checker #(
    .ASSERT_THR  (ASSERT_THR),
    .QUIET_LIMIT (QUIET_LIMIT),
    .CNT_W       (CNT_W),
    .WCW         ($clog2(ASSERT_WIN + 1)),
    .RW          ($clog2(QUIET_LIMIT + 2))
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .samp_valid (samp_valid),
    .samp_early (samp_early),
    .samp_mid   (samp_mid),
    .samp_late  (samp_late),
    .alarm_q    (alarm_q),
    .err_count  (err_count),
    .win_cnt_q  (win_cnt_q),
    .run_q      (run_q)
);

// File: tb/sim_ber_los_detector.sv
module sim_ber_los_detector;
    localparam int W  = 8;
    localparam int TH = 3;
    localparam int CW = 32;
    localparam int CM = 2;
    localparam int QL = 16;
    localparam int NB = 8;
    localparam int CMAX = (1 << NB) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic v = 1'b0, a = 1'b0, t = 1'b0, b = 1'b0;
    logic los0, los1;
    logic [NB-1:0] cnt0, cnt1;

    always #5 clk = ~clk;

    ber_los_detector #(.ASSERT_WIN(W), .ASSERT_THR(TH), .CLEAR_WIN(CW), .CLEAR_MAX(CM),
        .QUIET_LIMIT(QL), .CNT_W(NB), .INVERT(1'b0)) u0 (
        .clk(clk), .rst(rst), .samp_valid(v), .samp_early(a), .samp_mid(t),
        .samp_late(b), .los(los0), .err_count(cnt0));

    ber_los_detector #(.ASSERT_WIN(W), .ASSERT_THR(TH), .CLEAR_WIN(CW), .CLEAR_MAX(CM),
        .QUIET_LIMIT(QL), .CNT_W(NB), .INVERT(1'b1)) u1 (
        .clk(clk), .rst(rst), .samp_valid(v), .samp_early(a), .samp_mid(t),
        .samp_late(b), .los(los1), .err_count(cnt1));

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // requirement-level model
    int m_alarm, m_cnt, m_run, m_bits, m_errs, m_ptr;
    int m_hist[W];

    function automatic void model_reset();
        m_alarm = 1; m_cnt = 0; m_run = 0; m_bits = 0; m_errs = 0; m_ptr = 0;
        for (int i = 0; i < W; i++) m_hist[i] = 0;
    endfunction

    function automatic void model_step(logic ea, logic et, logic eb);
        int e, tr, wsum, ev;
        e  = ((ea == eb) && (et != ea)) ? 1 : 0;
        tr = (ea != eb) ? 1 : 0;
        m_hist[m_ptr] = e;
        m_ptr = (m_ptr + 1) % W;
        wsum = 0;
        for (int i = 0; i < W; i++) wsum += m_hist[i];
        m_run = tr ? 0 : ((m_run > QL) ? m_run : m_run + 1);
        ev = (wsum >= TH || m_run > QL) ? 1 : 0;
        if (e && m_cnt < CMAX) m_cnt++;
        if (ev) begin
            m_alarm = 1; m_bits = 0; m_errs = 0;
        end else if (m_alarm) begin
            m_bits++; m_errs += e;
            if (m_bits == CW) begin
                if (m_errs <= CM) m_alarm = 0;
                m_bits = 0; m_errs = 0;
            end
        end
    endfunction

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check_eq({tag, " los"}, int'(los0), m_alarm);
        check_eq("R7 inverted los", int'(los1), 1 - m_alarm);
        check_eq({tag, " err_count"}, int'(cnt0), m_cnt);
    endtask

    task automatic drive(logic dv, logic da, logic dt, logic db, string tag);
        @(negedge clk);
        v = dv; a = da; t = dt; b = db;
        @(posedge clk);
        #1;
        if (dv) model_step(da, dt, db);
        compare(tag);
    endtask

    task automatic clean_bits(int n, string tag);
        for (int i = 0; i < n; i++) drive(1'b1, i[0], i[0], ~i[0], tag);
    endtask

    task automatic err_bit(string tag);
        drive(1'b1, 1'b0, 1'b1, 1'b0, tag);
    endtask

    initial begin
        int unused_seed;
        model_reset();
        unused_seed = $urandom(13);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check_eq("R8 reset los", int'(los0), 1);
        check_eq("R8 reset err_count", int'(cnt0), 0);
        check_eq("R7 reset inverted los", int'(los1), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1: all eight sample combinations
        for (int i = 0; i < 8; i++) drive(1'b1, i[2], i[1], i[0], "R1");
        check_eq("R1 two error combinations", int'(cnt0), 2);

        // R4: first block holds exactly CM errors and clears
        clean_bits(23, "R4");
        check_eq("R4 block not yet complete", int'(los0), 1);
        clean_bits(1, "R4");
        check_eq("R4 clear at block end", int'(los0), 0);
        clean_bits(10, "R4");

        // R9: idle cycles carrying error patterns
        for (int i = 0; i < 20; i++) drive(1'b0, 1'b1, 1'b0, 1'b1, "R9");
        check_eq("R9 idle err_count unchanged", int'(cnt0), 2);

        // R2: two errors in a window stay quiet, the third sets the alarm
        err_bit("R2"); err_bit("R2");
        check_eq("R2 two errors no alarm", int'(los0), 0);
        clean_bits(8, "R2");
        err_bit("R2"); err_bit("R2");
        check_eq("R2 below threshold", int'(los0), 0);
        err_bit("R2");
        check_eq("R2 threshold reached", int'(los0), 1);

        // R6: window events restart the block; 37th clean bit clears
        clean_bits(36, "R6");
        check_eq("R6 restarted block not complete", int'(los0), 1);
        clean_bits(1, "R6");
        check_eq("R6 clear after restarted block", int'(los0), 0);

        // R3: block with CM+1 spaced errors keeps the alarm
        err_bit("R3"); err_bit("R3"); err_bit("R3");
        clean_bits(13, "R3");
        for (int i = 0; i < 24; i++) begin
            if (i == 0 || i == 10 || i == 20) err_bit("R3");
            else clean_bits(1, "R3");
        end
        check_eq("R3 too many errors, alarm held", int'(los0), 1);
        clean_bits(31, "R3");
        check_eq("R3 next block not complete", int'(los0), 1);
        clean_bits(1, "R3");
        check_eq("R3 clean block clears", int'(los0), 0);

        // R4: exactly CM spaced errors in a block clears
        err_bit("R4"); err_bit("R4"); err_bit("R4");
        clean_bits(13, "R4");
        for (int i = 0; i < 24; i++) begin
            if (i == 0 || i == 10) err_bit("R4");
            else clean_bits(1, "R4");
            if (i == 22) check_eq("R4 limit block not complete", int'(los0), 1);
        end
        check_eq("R4 limit block clears", int'(los0), 0);

        // R5: no-transition run
        for (int i = 0; i < QL; i++) drive(1'b1, 1'b0, 1'b0, 1'b0, "R5");
        check_eq("R5 run at limit no alarm", int'(los0), 0);
        drive(1'b1, 1'b0, 1'b0, 1'b0, "R5");
        check_eq("R5 run over limit alarm", int'(los0), 1);
        for (int i = 0; i < 20; i++) drive(1'b1, 1'b1, 1'b1, 1'b1, "R5");
        check_eq("R5 constant ones keep alarm", int'(los0), 1);
        clean_bits(40, "R5");

        // R6: pseudo-random data with sparse injected errors
        for (int i = 0; i < 3000; i++) begin
            logic ra, rb;
            ra = 1'($urandom);
            rb = 1'($urandom);
            if (($urandom % 16) == 0) drive(1'b1, ra, ~ra, ra, "R6");
            else if (ra != rb) drive(1'b1, ra, 1'($urandom), rb, "R6");
            else drive(1'b1, ra, ra, rb, "R6");
            if (($urandom % 8) == 0) drive(1'b0, 1'b0, 1'b1, 1'b0, "R9");
        end

        // R1: saturation
        for (int i = 0; i < 300; i++) err_bit("R1");
        check_eq("R1 err_count saturates", int'(cnt0), CMAX);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule